// File: doc/BRIEF.md
# Threshold Offset Register Pair with Sequenced Load and Readback

This block stores the two 10-bit thresholds that a FIFO's flag logic compares against. One threshold sets the almost-empty point and the other sets the almost-full point. The thresholds are loaded from the write-clock side and read back on the read-clock side. A shared active-low load select decides what each enable does. With load select HIGH, the write and read enables pass through as ordinary FIFO access strobes. With load select LOW, the same enables address the threshold registers instead.

Each side steps through the two registers with its own one-bit sequence pointer. The order is the empty threshold, then the full threshold, then back to the empty threshold. A pointer moves only when an access actually takes place, so a load or readback that is cut short resumes at the register where it stopped. Readback returns the threshold zero-extended to the data width, together with a one-cycle valid strobe.

Top module: `offreg_ctl`

## Requirements
- R1: While `rst_ni` is LOW and just after it is released, both thresholds equal the default 7, `rb_valid_o` is 0 and `rb_data_o` is 0.
- R2: On a write-clock edge with `ld_ni`=0 and `wen_ni`=0, `din_i[9:0]` is stored into the register the write pointer selects, and the other register keeps its value.
- R3: Successive loads alternate targets: empty threshold first, then full threshold, then empty threshold again, and so on without end.
- R4: Raising `ld_ni` between loads keeps the write pointer where it is, so the next load goes to the register after the last one written.
- R5: On a write-clock edge with `ld_ni`=0 and `wen_ni`=1, neither threshold changes and the write pointer does not move.
- R6: With `ld_ni`=1 and `wen_ni`=0, `fifo_wr_o` is 1 and no threshold changes. Otherwise `fifo_wr_o` is 0.
- R7: On a read-clock edge with `ld_ni`=0 and `ren_ni`=0, the next cycle shows `rb_valid_o`=1 and `rb_data_o` holding the register the read pointer selects. The read pointer then advances empty, full, empty and so on, independently of the write pointer.
- R8: With `ld_ni`=1 and `ren_ni`=0, `fifo_rd_o` is 1, no readback takes place (`rb_valid_o` is 0 after the edge) and the read pointer holds. Otherwise `fifo_rd_o` is 0. `rb_data_o` keeps its last value whenever no readback takes place.
- R9: Reset returns both sequence pointers to the empty-threshold position, even when it comes partway through a sequence.
- R10: `rb_data_o[17:10]` is always 0, because readback zero-extends the 10-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write-side clock |
| rclk_i | input | 1 | Read-side clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_ni | input | 1 | Load select, active low: register access instead of FIFO access |
| wen_ni | input | 1 | Write enable, active low |
| ren_ni | input | 1 | Read enable, active low |
| din_i | input | 18 | Write data; bits 9:0 feed the thresholds |
| empty_ofs_o | output | 10 | Almost-empty threshold to the flag logic |
| full_ofs_o | output | 10 | Almost-full threshold to the flag logic |
| fifo_wr_o | output | 1 | Ordinary FIFO write strobe |
| fifo_rd_o | output | 1 | Ordinary FIFO read strobe |
| rb_data_o | output | 18 | Readback word, zero-extended threshold |
| rb_valid_o | output | 1 | Readback word valid for one cycle |

## Verification
Loading a threshold and reading one back must never share an edge, but a readback can share an edge with a suppressed load, where `ld_ni`=0, `wen_ni`=1 and `ren_ni`=0. On that edge the readback must advance only the read pointer while the write side holds both value and position. The bench drives both clocks in phase so both sides sample the same edge. It steers these overlaps both directly and through random enable patterns, filtering out only the forbidden load-plus-readback combination. Every cycle it compares both thresholds, both strobes and the readback word against a behavioural model that tracks the two pointers as plain integers.

// File: rtl/offreg_pkg.sv
`timescale 1ns/1ps
package offreg_pkg;
  localparam int NUM_OFS = 2;

  typedef enum logic {
    OFS_EMPTY = 1'b0,
    OFS_FULL  = 1'b1
  } ofs_sel_e;
endpackage

// File: rtl/offreg_seq_ptr.sv
`timescale 1ns/1ps
module offreg_seq_ptr #(
  parameter int NUM   = 2,
  localparam int PTR_W = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [PTR_W-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (step_i) ptr_o <= (ptr_o == PTR_W'(NUM-1)) ? '0 : ptr_o + 1'b1;
  end
endmodule

// File: rtl/offreg_decode.sv
`timescale 1ns/1ps
module offreg_decode (
  input  logic ld_ni,
  input  logic wen_ni,
  input  logic ren_ni,
  output logic ofs_wr_o,
  output logic ofs_rd_o,
  output logic fifo_wr_o,
  output logic fifo_rd_o
);
  always_comb begin
    ofs_wr_o  = !ld_ni && !wen_ni;
    ofs_rd_o  = !ld_ni && !ren_ni;
    fifo_wr_o =  ld_ni && !wen_ni;
    fifo_rd_o =  ld_ni && !ren_ni;
  end
endmodule

// File: rtl/offreg_wr_bank.sv
`timescale 1ns/1ps
module offreg_wr_bank
  import offreg_pkg::*;
#(
  parameter int DATA_W      = 18,
  parameter int OFS_W       = 10,
  parameter int OFS_DEFAULT = 7,
  localparam int PTR_W      = $clog2(NUM_OFS)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            load_i,
  input  logic [DATA_W-1:0]               din_i,
  output logic [NUM_OFS-1:0][OFS_W-1:0]   ofs_o
);
  logic [PTR_W-1:0] wptr;

  offreg_seq_ptr #(.NUM(NUM_OFS)) u_wptr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(load_i),
    .ptr_o (wptr)
  );

  for (genvar g = 0; g < NUM_OFS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            ofs_o[g] <= OFS_W'(OFS_DEFAULT);
      else if (load_i && wptr == PTR_W'(g))   ofs_o[g] <= din_i[OFS_W-1:0];
    end
  end
endmodule

// File: rtl/offreg_rd_port.sv
`timescale 1ns/1ps
module offreg_rd_port
  import offreg_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int OFS_W  = 10,
  localparam int PTR_W = $clog2(NUM_OFS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          rd_i,
  input  logic [NUM_OFS-1:0][OFS_W-1:0] ofs_i,
  output logic [DATA_W-1:0]             rb_data_o,
  output logic                          rb_valid_o
);
  logic [PTR_W-1:0] rptr;
  logic [OFS_W-1:0] sel_ofs;

  offreg_seq_ptr #(.NUM(NUM_OFS)) u_rptr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(rd_i),
    .ptr_o (rptr)
  );

  assign sel_ofs = ofs_i[rptr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rb_data_o  <= '0;
      rb_valid_o <= 1'b0;
    end else begin
      rb_valid_o <= rd_i;
      if (rd_i) rb_data_o <= DATA_W'(sel_ofs);  // zero-extend
    end
  end
endmodule

// File: rtl/offreg_ctl.sv
`timescale 1ns/1ps
module offreg_ctl
  import offreg_pkg::*;
#(
  parameter int DATA_W      = 18,
  parameter int OFS_W       = 10,
  parameter int OFS_DEFAULT = 7
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              ld_ni,
  input  logic              wen_ni,
  input  logic              ren_ni,
  input  logic [DATA_W-1:0] din_i,
  output logic [OFS_W-1:0]  empty_ofs_o,
  output logic [OFS_W-1:0]  full_ofs_o,
  output logic              fifo_wr_o,
  output logic              fifo_rd_o,
  output logic [DATA_W-1:0] rb_data_o,
  output logic              rb_valid_o
);
  logic                          ofs_wr, ofs_rd;
  logic [NUM_OFS-1:0][OFS_W-1:0] ofs;

  offreg_decode u_dec (
    .ld_ni    (ld_ni),
    .wen_ni   (wen_ni),
    .ren_ni   (ren_ni),
    .ofs_wr_o (ofs_wr),
    .ofs_rd_o (ofs_rd),
    .fifo_wr_o(fifo_wr_o),
    .fifo_rd_o(fifo_rd_o)
  );

  offreg_wr_bank #(
    .DATA_W     (DATA_W),
    .OFS_W      (OFS_W),
    .OFS_DEFAULT(OFS_DEFAULT)
  ) u_wr (
    .clk_i (wclk_i),
    .rst_ni(rst_ni),
    .load_i(ofs_wr),
    .din_i (din_i),
    .ofs_o (ofs)
  );

  // thresholds are quasi-static; readback never overlaps a load
  offreg_rd_port #(
    .DATA_W(DATA_W),
    .OFS_W (OFS_W)
  ) u_rd (
    .clk_i     (rclk_i),
    .rst_ni    (rst_ni),
    .rd_i      (ofs_rd),
    .ofs_i     (ofs),
    .rb_data_o (rb_data_o),
    .rb_valid_o(rb_valid_o)
  );

  assign empty_ofs_o = ofs[OFS_EMPTY];
  assign full_ofs_o  = ofs[OFS_FULL];
endmodule

// File: rtl/offreg_ctl_chk.sv
`timescale 1ns/1ps
module offreg_ctl_chk #(
  parameter int DATA_W = 18,
  parameter int OFS_W  = 10
) (
  input logic              wclk_i,
  input logic              rclk_i,
  input logic              rst_ni,
  input logic              ld_ni,
  input logic              wen_ni,
  input logic              ren_ni,
  input logic [OFS_W-1:0]  empty_ofs_o,
  input logic [OFS_W-1:0]  full_ofs_o,
  input logic [DATA_W-1:0] rb_data_o,
  input logic              rb_valid_o
);
  assert_one_target_R2: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (!ld_ni && !wen_ni) |=>
      !((empty_ofs_o != $past(empty_ofs_o)) && (full_ofs_o != $past(full_ofs_o))));

  assert_hold_no_wen_R5: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (!ld_ni && wen_ni) |=> ($stable(empty_ofs_o) && $stable(full_ofs_o)));

  assert_fifo_mode_keeps_ofs_R6: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    ld_ni |=> ($stable(empty_ofs_o) && $stable(full_ofs_o)));

  assert_rb_valid_R7: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!ld_ni && !ren_ni) |=> rb_valid_o);

  assert_no_rb_fifo_mode_R8: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    ld_ni |=> !rb_valid_o);

  assert_rb_hold_R8: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (ld_ni || ren_ni) |=> $stable(rb_data_o));

  assert_zero_ext_R10: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    rb_data_o[DATA_W-1:OFS_W] == '0);
endmodule

bind offreg_ctl offreg_ctl_chk #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_chk (
  .wclk_i     (wclk_i),
  .rclk_i     (rclk_i),
  .rst_ni     (rst_ni),
  .ld_ni      (ld_ni),
  .wen_ni     (wen_ni),
  .ren_ni     (ren_ni),
  .empty_ofs_o(empty_ofs_o),
  .full_ofs_o (full_ofs_o),
  .rb_data_o  (rb_data_o),
  .rb_valid_o (rb_valid_o)
);

// File: tb/offreg_ctl_test.sv
`timescale 1ns/1ps
module offreg_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_n = 1'b1, wen_n = 1'b1, ren_n = 1'b1;
  logic [17:0] din = '0;
  logic [9:0]  empty_ofs, full_ofs;
  logic        fifo_wr, fifo_rd, rb_valid;
  logic [17:0] rb_data;

  int total = 0, bad = 0;
  bit done = 0;

  // reference model state
  int m_empty = 7, m_full = 7, m_wp = 0, m_rp = 0, m_rbd = 0, m_rbv = 0;

  always #2 clk = ~clk;  // 250 MHz

  offreg_ctl uut (
    .wclk_i     (clk),
    .rclk_i     (clk),
    .rst_ni     (rst_n),
    .ld_ni      (ld_n),
    .wen_ni     (wen_n),
    .ren_ni     (ren_n),
    .din_i      (din),
    .empty_ofs_o(empty_ofs),
    .full_ofs_o (full_ofs),
    .fifo_wr_o  (fifo_wr),
    .fifo_rd_o  (fifo_rd),
    .rb_data_o  (rb_data),
    .rb_valid_o (rb_valid)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_empty = 7; m_full = 7; m_wp = 0; m_rp = 0; m_rbd = 0; m_rbv = 0;
    end else begin
      m_rbv = 0;
      if (!ld_n && !ren_n) begin
        m_rbd = (m_rp == 0) ? m_empty : m_full;
        m_rbv = 1;
        m_rp  = 1 - m_rp;
      end
      if (!ld_n && !wen_n) begin
        if (m_wp == 0) m_empty = int'(din[9:0]);
        else           m_full  = int'(din[9:0]);
        m_wp = 1 - m_wp;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cmp_model();
    chk("R2 R3 R4 R5 empty threshold", int'(empty_ofs), m_empty);
    chk("R2 R3 R4 R5 full threshold",  int'(full_ofs),  m_full);
    chk("R7 R8 rb_valid",              int'(rb_valid),  m_rbv);
    chk("R7 R10 rb_data",              int'(rb_data),   m_rbd);
    chk("R6 fifo_wr", int'(fifo_wr), int'(ld_n && !wen_n));
    chk("R8 fifo_rd", int'(fifo_rd), int'(ld_n && !ren_n));
  endtask

  // called at a negedge; drives, lets one edge pass, compares
  task automatic cyc(bit ld, bit wen, bit ren, logic [17:0] d);
    if (!ld && !wen && !ren) ren = 1'b1;  // never load and read back together
    ld_n = ld; wen_n = wen; ren_n = ren; din = d;
    @(posedge clk);
    @(negedge clk);
    cmp_model();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    ld_n = 1'b1; wen_n = 1'b1; ren_n = 1'b1;
  endtask

  initial begin
    @(negedge clk);
    chk("R1 empty in reset", int'(empty_ofs), 7);
    chk("R1 full in reset",  int'(full_ofs),  7);
    chk("R1 rb_valid in reset", int'(rb_valid), 0);
    chk("R1 rb_data in reset",  int'(rb_data),  0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_model();
    chk("R1 empty after reset", int'(empty_ofs), 7);
    chk("R1 full after reset",  int'(full_ofs),  7);

    cyc(0, 0, 1, 18'h21234);
    chk("R2 first load to empty", int'(empty_ofs), 'h234);
    chk("R2 full untouched",      int'(full_ofs),  7);
    cyc(0, 0, 1, 18'h00155);
    chk("R3 second load to full", int'(full_ofs), 'h155);
    cyc(0, 0, 1, 18'h000AA);
    chk("R3 third load to empty", int'(empty_ofs), 'h0AA);
    chk("R3 full kept",           int'(full_ofs),  'h155);

    cyc(1, 0, 1, 18'h003FF);
    chk("R6 fifo write strobe", int'(fifo_wr), 1);
    chk("R6 empty unchanged",   int'(empty_ofs), 'h0AA);
    chk("R6 full unchanged",    int'(full_ofs),  'h155);
    cyc(0, 0, 1, 18'h00111);
    chk("R4 resume at full", int'(full_ofs), 'h111);

    cyc(0, 1, 1, 18'h00222);
    cyc(0, 1, 1, 18'h00222);
    chk("R5 empty held", int'(empty_ofs), 'h0AA);
    chk("R5 full held",  int'(full_ofs),  'h111);
    cyc(0, 0, 1, 18'h00333);
    chk("R5 pointer held, load to empty", int'(empty_ofs), 'h333);

    cyc(0, 1, 0, 18'h0);
    chk("R7 readback valid",       int'(rb_valid), 1);
    chk("R7 readback empty first", int'(rb_data), 'h333);
    chk("R5 readback beside held load", int'(full_ofs), 'h111);
    cyc(1, 1, 0, 18'h0);
    chk("R8 fifo read strobe", int'(fifo_rd), 1);
    chk("R8 no readback",      int'(rb_valid), 0);
    chk("R8 data held",        int'(rb_data), 'h333);
    cyc(0, 1, 0, 18'h0);
    chk("R8 read pointer held, full next", int'(rb_data), 'h111);

    cyc(0, 0, 1, 18'h3FFFF);
    chk("R10 load masked to 10 bits", int'(full_ofs), 'h3FF);
    cyc(0, 1, 0, 18'h0);
    chk("R7 alternation back to empty", int'(rb_data), 'h333);
    cyc(0, 1, 0, 18'h0);
    chk("R10 zero-extended readback", int'(rb_data), 'h003FF);
    cyc(0, 1, 0, 18'h0);
    cyc(0, 0, 1, 18'h00050);
    chk("R3 load to empty", int'(empty_ofs), 'h050);

    // both pointers now sit at the full position
    @(negedge clk);
    do_reset();
    @(negedge clk);
    cmp_model();
    chk("R9 empty default", int'(empty_ofs), 7);
    cyc(0, 0, 1, 18'h000C3);
    chk("R9 write pointer reset to empty", int'(empty_ofs), 'h0C3);
    chk("R9 full stays default",           int'(full_ofs),  7);
    cyc(0, 1, 0, 18'h0);
    chk("R9 read pointer reset to empty", int'(rb_data), 'h0C3);

    for (int i = 0; i < 600; i++) begin
      cyc(1'($urandom_range(0, 2) == 0), 1'($urandom), 1'($urandom), 18'($urandom));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule